// File: doc/BRIEF.md
# Absolute-Time Event and Clock Scheduler

This block watches a 64-bit time count whose unit is 10 ns. Another part of the chip provides that count and may run it freely or steer it to an outside reference. The block drives one digital line from programmed absolute time stamps. In event mode it raises the line for a single clock cycle once the time count reaches a programmed instant. In clock mode it produces a square wave that begins at a programmed start instant and ends near a programmed stop instant. Its high and low durations are programmed as whole numbers of 10 ns units.

Every edge is scheduled on the time scale itself. Each next edge instant is the previous scheduled instant plus the programmed duration, and the sample time plays no part in it. The block compares with greater-or-equal, so a forward jump of the time count delays an edge and never loses it. When the high and low durations each equal half a second and the start sits on a whole second, the line rises exactly on every seconds boundary.

Software loads the settings through a plain write port, then issues single-cycle `arm` and `disarm` strobes. The status pins show whether the block is waiting for its start instant or is producing output. Two flags report why an arm request was refused.

Top module: `sched_time_gen`

## Requirements
- R1: After reset, `out_line`, `armed`, `running`, `late_err` and `cfg_err` are all 0. `out_line` is never 1 while `running` is 0.
- R2: Write addresses are 0 for the mode (bit 0: 0 = event, 1 = clock), 1 for the start instant, 2 for the stop instant, 3 for the high duration and 4 for the low duration. In event mode, `out_line` is 1 for exactly one cycle. That cycle follows the first edge at which the armed block samples `time_now >= start`. The block then returns to idle.
- R3: Firing uses greater-or-equal. A step of `time_now` from below the start instant to beyond it still fires, on the first edge that samples the larger value.
- R4: An arm request while idle with `start < time_now` sets `late_err` on the next cycle and leaves the block idle. `start == time_now` is accepted. Each arm request clears both error flags before it is evaluated.
- R5: In clock mode, `out_line` is high on the cycle after the first sample with `time_now >= start`. Edges then follow at start+H, start+H+L, start+2H+L and so on, where H and L are the programmed durations in time units.
- R6: When the stop instant is reached during a high phase, that phase completes at its scheduled instant and the block goes idle with the line low. When it is reached during a low phase, the block goes idle at once.
- R7: An arm request in clock mode with a zero high or zero low duration sets `cfg_err` and leaves the block idle.
- R8: Writes to any setting are ignored while `armed` or `running` is 1.
- R9: `disarm` returns the block to idle on the next cycle, with `out_line`, `armed` and `running` all 0. It takes priority over a simultaneous `arm`.
- R10: With H = L = 50,000,000 and a start on a whole second, rising edges occur exactly on each seconds boundary and falling edges on each half second.
- R11: `armed` is 1 while the block waits for its start instant. `running` is 1 while it produces the pulse or a clock phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one edge per time-count step |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | 64 | Current synchronized time in 10 ns units |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | 3 | Setting address (0 mode, 1 start, 2 stop, 3 high, 4 low) |
| cfg_wdata | input | 64 | Setting write data |
| arm | input | 1 | Single-cycle request to start waiting for the start instant |
| disarm | input | 1 | Single-cycle request to abandon and return to idle |
| out_line | output | 1 | Generated event or clock line, idle low |
| armed | output | 1 | Waiting for the start instant |
| running | output | 1 | Producing the event pulse or clock phases |
| late_err | output | 1 | Last arm request refused because start was in the past |
| cfg_err | output | 1 | Last arm request refused because a clock duration was zero |

## Verification
The assertions check on every cycle that settings hold still while the block is busy, that a refused arm lands in idle with the right flag, that an armed block fires on the cycle after its start instant is sampled, that disarm always empties the block, and that event pulses last one cycle. Only the bench scenarios can show that edge instants fall at the right absolute times over many periods. They cover the stop rule that completes a high phase, the whole-second alignment of the slow clock, and the firing point under uneven time steps.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_PULSE = 3'd2,
    ST_HIGH  = 3'd3,
    ST_LOW   = 3'd4
  } sched_state_e;

  localparam logic [2:0] A_MODE  = 3'd0;
  localparam logic [2:0] A_START = 3'd1;
  localparam logic [2:0] A_STOP  = 3'd2;
  localparam logic [2:0] A_HIGH  = 3'd3;
  localparam logic [2:0] A_LOW   = 3'd4;
endpackage

// File: rtl/sched_cfg_regs.sv
module sched_cfg_regs
  import sched_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int DUR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [TIME_W-1:0] wdata,
  output logic              mode_clk,
  output logic [TIME_W-1:0] start_t,
  output logic [TIME_W-1:0] stop_t,
  output logic [DUR_W-1:0]  hi_dur,
  output logic [DUR_W-1:0]  lo_dur
);
  logic wr_ok;
  assign wr_ok = we && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_clk <= 1'b0;
      start_t  <= '0;
      stop_t   <= '1;
      hi_dur   <= '0;
      lo_dur   <= '0;
    end else if (wr_ok) begin
      case (addr)
        A_MODE:  mode_clk <= wdata[0];
        A_START: start_t  <= wdata;
        A_STOP:  stop_t   <= wdata;
        A_HIGH:  hi_dur   <= wdata[DUR_W-1:0];
        A_LOW:   lo_dur   <= wdata[DUR_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sched_phase_seq.sv
module sched_phase_seq
  import sched_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int DUR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_now,
  input  logic              arm,
  input  logic              disarm,
  input  logic              mode_clk,
  input  logic [TIME_W-1:0] start_t,
  input  logic [TIME_W-1:0] stop_t,
  input  logic [DUR_W-1:0]  hi_dur,
  input  logic [DUR_W-1:0]  lo_dur,
  output logic              out_line,
  output logic              armed,
  output logic              running,
  output logic              late_err,
  output logic              cfg_err
);
  sched_state_e      state;
  logic [TIME_W-1:0] edge_t;
  logic [TIME_W-1:0] hi_ext, lo_ext;
  logic              edge_due, stop_due, dur_bad;

  assign hi_ext   = TIME_W'(hi_dur);
  assign lo_ext   = TIME_W'(lo_dur);
  assign edge_due = time_now >= edge_t;
  assign stop_due = time_now >= stop_t;
  assign dur_bad  = mode_clk && (hi_dur == '0 || lo_dur == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      edge_t   <= '0;
      late_err <= 1'b0;
      cfg_err  <= 1'b0;
    end else if (disarm) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (arm) begin
          late_err <= 1'b0;
          cfg_err  <= 1'b0;
          if (dur_bad)                 cfg_err  <= 1'b1;
          else if (start_t < time_now) late_err <= 1'b1;
          else begin
            state  <= ST_WAIT;
            edge_t <= start_t;
          end
        end
        ST_WAIT: if (edge_due) begin
          if (mode_clk) begin
            state  <= ST_HIGH;
            edge_t <= edge_t + hi_ext;
          end else begin
            state <= ST_PULSE;
          end
        end
        ST_PULSE: state <= ST_IDLE;
        ST_HIGH: if (edge_due) begin
          if (stop_due) state <= ST_IDLE;
          else begin
            state  <= ST_LOW;
            edge_t <= edge_t + lo_ext;
          end
        end
        ST_LOW: begin
          if (stop_due) state <= ST_IDLE;
          else if (edge_due) begin
            state  <= ST_HIGH;
            edge_t <= edge_t + hi_ext;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign out_line = (state == ST_HIGH) || (state == ST_PULSE);
  assign armed    = (state == ST_WAIT);
  assign running  = (state == ST_HIGH) || (state == ST_LOW) || (state == ST_PULSE);
endmodule

// File: rtl/sched_time_gen.sv
module sched_time_gen #(
  parameter int TIME_W = 64,
  parameter int DUR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_now,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [TIME_W-1:0] cfg_wdata,
  input  logic              arm,
  input  logic              disarm,
  output logic              out_line,
  output logic              armed,
  output logic              running,
  output logic              late_err,
  output logic              cfg_err
);
  logic              mode_clk;
  logic [TIME_W-1:0] start_t, stop_t;
  logic [DUR_W-1:0]  hi_dur, lo_dur;
  logic              busy;

  assign busy = armed || running;

  sched_cfg_regs #(.TIME_W(TIME_W), .DUR_W(DUR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .mode_clk(mode_clk), .start_t(start_t), .stop_t(stop_t),
    .hi_dur(hi_dur), .lo_dur(lo_dur)
  );

  sched_phase_seq #(.TIME_W(TIME_W), .DUR_W(DUR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .time_now(time_now),
    .arm(arm), .disarm(disarm),
    .mode_clk(mode_clk), .start_t(start_t), .stop_t(stop_t),
    .hi_dur(hi_dur), .lo_dur(lo_dur),
    .out_line(out_line), .armed(armed), .running(running),
    .late_err(late_err), .cfg_err(cfg_err)
  );
endmodule

// File: rtl/sched_time_gen_chk.sv
module sched_time_gen_chk #(
  parameter int TIME_W = 64,
  parameter int DUR_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TIME_W-1:0] time_now,
  input logic              arm,
  input logic              disarm,
  input logic              mode_clk,
  input logic [TIME_W-1:0] start_t,
  input logic [TIME_W-1:0] stop_t,
  input logic [DUR_W-1:0]  hi_dur,
  input logic [DUR_W-1:0]  lo_dur,
  input logic              out_line,
  input logic              armed,
  input logic              running,
  input logic              late_err,
  input logic              cfg_err
);
  logic idle, zero_dur;
  assign idle     = !armed && !running;
  assign zero_dur = mode_clk && (hi_dur == '0 || lo_dur == '0);

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !out_line);

  // R2
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_line && !mode_clk |=> !out_line);

  // R3
  fire_ge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !disarm && time_now >= start_t |=> running && out_line);

  // R4
  late_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle && arm && !disarm && !zero_dur && start_t < time_now |=> late_err && !armed && !running);

  // R7
  zero_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle && arm && !disarm && zero_dur |=> cfg_err && !armed && !running);

  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed || running |=> $stable(mode_clk) && $stable(start_t) && $stable(stop_t)
                         && $stable(hi_dur) && $stable(lo_dur));

  // R9
  disarm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disarm |=> !armed && !running && !out_line);

  // R11
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(armed && running));
endmodule

bind sched_time_gen sched_time_gen_chk #(.TIME_W(TIME_W), .DUR_W(DUR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .time_now(time_now), .arm(arm), .disarm(disarm),
  .mode_clk(mode_clk), .start_t(start_t), .stop_t(stop_t),
  .hi_dur(hi_dur), .lo_dur(lo_dur), .out_line(out_line), .armed(armed),
  .running(running), .late_err(late_err), .cfg_err(cfg_err)
);

// File: tb/test_sched_time_gen.sv
module test_sched_time_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_now = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [63:0] cfg_wdata = '0;
  logic        arm = 1'b0;
  logic        disarm = 1'b0;
  logic        out_line, armed, running, late_err, cfg_err;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sched_time_gen i_sched_time_gen (
    .clk(clk), .rst_n(rst_n), .time_now(time_now),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .arm(arm), .disarm(disarm), .out_line(out_line), .armed(armed),
    .running(running), .late_err(late_err), .cfg_err(cfg_err)
  );

  // Event vectors: start instant, time at arm, time step per cycle
  localparam int NV = 5;
  localparam logic [63:0] V_START [NV] = '{64'd100, 64'd100, 64'd100, 64'd100, 64'd1000};
  localparam logic [63:0] V_T0    [NV] = '{64'd90,  64'd100, 64'd50,  64'd101, 64'd0};
  localparam logic [63:0] V_STEP  [NV] = '{64'd1,   64'd5,   64'd7,   64'd1,   64'd300};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic step_time(input logic [63:0] t);
    @(negedge clk);
    time_now = t;
    @(posedge clk); #1;
  endtask

  task automatic do_arm(input logic [63:0] t);
    @(negedge clk);
    time_now = t; arm = 1'b1;
    @(posedge clk); #1;
    arm = 1'b0;
  endtask

  task automatic do_disarm();
    @(negedge clk);
    disarm = 1'b1;
    @(posedge clk); #1;
    disarm = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 out", out_line, 0);
    chk("R1 armed", armed, 0);
    chk("R1 running", running, 0);
    chk("R1 late", late_err, 0);
    chk("R1 cfgerr", cfg_err, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;

    // R2 R3 R4 event vectors
    for (int v = 0; v < NV; v++) begin
      logic exp_late;
      int   exp_k, first, highs;
      wr(3'd0, 64'd0);
      wr(3'd1, V_START[v]);
      do_arm(V_T0[v]);
      exp_late = V_START[v] < V_T0[v];
      chk("R4 late flag", late_err, exp_late);
      chk("R11 armed after arm", armed, !exp_late);
      if (!exp_late) begin
        exp_k = int'((V_START[v] - V_T0[v] + V_STEP[v] - 1) / V_STEP[v]);
        if (exp_k < 1) exp_k = 1;
        first = 0; highs = 0;
        for (int k = 1; k <= 40; k++) begin
          step_time(V_T0[v] + 64'(k) * V_STEP[v]);
          if (out_line) begin
            highs++;
            if (first == 0) first = k;
          end
        end
        chk("R3 fire cycle", first, exp_k);
        chk("R2 pulse width", highs, 1);
        chk("R2 back idle", armed | running, 0);
      end
    end

    // R5 R6 clock with stop inside a high phase
    wr(3'd0, 64'd1);
    wr(3'd1, 64'd200);
    wr(3'd2, 64'd217);
    wr(3'd3, 64'd3);
    wr(3'd4, 64'd2);
    do_arm(64'd195);
    chk("R11 clock armed", armed, 1);
    for (int t = 196; t <= 225; t++) begin
      logic e_hi;
      e_hi = (t >= 200) && (t < 218) && (((t - 200) % 5) < 3);
      step_time(64'(t));
      if (t == 217) chk("R6 high phase completes", out_line, 1);
      else if (t == 218) chk("R6 idle after stop", running, 0);
      else chk("R5 clock level", out_line, e_hi);
    end

    // R7 zero high duration refused
    wr(3'd3, 64'd0);
    do_arm(64'd0);
    chk("R7 cfg_err", cfg_err, 1);
    chk("R7 stays idle", armed | running, 0);
    wr(3'd3, 64'd3);
    do_arm(64'd0);
    chk("R4 flags cleared on arm", cfg_err, 0);
    do_disarm();
    chk("R9 disarm from armed", armed, 0);

    // R8 writes ignored while armed
    wr(3'd0, 64'd0);
    wr(3'd1, 64'd1000);
    do_arm(64'd0);
    wr(3'd1, 64'd5);
    for (int t = 1; t <= 10; t++) step_time(64'(t));
    chk("R8 no fire from ignored write", out_line, 0);
    chk("R8 still armed", armed, 1);
    do_disarm();
    do_arm(64'd10);
    chk("R8 start kept (not late)", late_err, 0);
    chk("R8 rearmed", armed, 1);
    do_disarm();

    // R10 seconds-aligned clock, then R9 disarm while running
    wr(3'd0, 64'd1);
    wr(3'd1, 64'd200_000_000);
    wr(3'd2, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(3'd3, 64'd50_000_000);
    wr(3'd4, 64'd50_000_000);
    do_arm(64'd190_000_000);
    for (int k = 1; k <= 60; k++) begin
      logic [63:0] t;
      logic e_hi;
      t = 64'd190_000_000 + 64'(k) * 64'd5_000_000;
      e_hi = (t >= 64'd200_000_000) && (((t - 64'd200_000_000) % 64'd100_000_000) < 64'd50_000_000);
      step_time(t);
      chk("R10 second-aligned level", out_line, e_hi);
    end
    chk("R11 running", running, 1);
    do_disarm();
    chk("R9 out low", out_line, 0);
    chk("R9 running low", running, 0);

    // R9 disarm wins over arm
    @(negedge clk);
    arm = 1'b1; disarm = 1'b1; time_now = 64'd0;
    @(posedge clk); #1;
    arm = 1'b0; disarm = 1'b0;
    chk("R9 disarm priority", armed | running, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule